// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Aggregator

This block collects up to thirty-two interrupt request lines from peripherals and folds them into one interrupt request towards a processor. Each request line owns one bit of a pending word. A rising level on the line sets its bit, and a falling level clears it. A mask word chooses which pending bits may reach the processor. The processor request is a registered OR of the masked pending word.

Software reaches the block through a single-cycle register port with a byte address and a data word as wide as the source count. Software can drop pending bits by writing ones to them, or it can load the whole pending word in one write. It can program the mask and read the pending word either raw or masked. Writes are sampled on the clock edge. Read data is returned combinationally in the cycle in which the read strobe is high. Line number i always drives pending bit i. A board that numbers its lines from the most significant end wires peripheral k to line 31-k.

Top module: `intc32_top`

## Requirements
- R1: After reset, the pending word, the mask word and the processor request are all zero, and every register reads back zero.
- R2: A low-to-high change on source line i sets pending bit i (offset 0x00) at the next clock edge.
- R3: A high-to-low change on source line i clears pending bit i at the next clock edge. A line that stays high does not set its bit again.
- R4: A write to offset 0x00 clears each pending bit whose data bit is 1 and keeps every other pending bit.
- R5: A write to offset 0x04 loads the pending word with the written data. A read of 0x04 returns the raw pending word.
- R6: Offset 0x08 holds the mask word. A write replaces it, and a read returns it.
- R7: A read of offset 0x0C returns the pending word ANDed with the mask word. A write to 0x0C changes nothing.
- R8: The processor request is high exactly when the masked pending word was nonzero at the previous clock edge, so it follows the change of a register by one clock.
- R9: A write to any other byte address, misaligned ones included, changes nothing, and a read there returns zero.
- R10: When a source change and a software write hit the same pending bit in the same cycle, the source change decides the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level request lines, line i drives pending bit i |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, zero when no read is in progress |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The lines are driven with a single bit, with a scattered multi-bit pattern and with a line that is held high. These patterns separate true edge detection from a level copy, and a shifted or reversed bit map from the correct one. Software writes use overlapping clear and load patterns, so that clearing cannot pass for a load or an XOR. The processor request is checked in the cycle right after the register change and one cycle later, which catches both a request with no register stage and one that never rises. Simultaneous source edges and writes on the same bit check the precedence rule. Masked-status writes and misaligned or unmapped addresses check that stray accesses leave the stored words untouched.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LOAD   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_LOAD,
    SEL_MASK,
    SEL_MASKED
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PEND:   return SEL_PEND;
      OFS_LOAD:   return SEL_LOAD;
      OFS_MASK:   return SEL_MASK;
      OFS_MASKED: return SEL_MASKED;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/intc_edge_det.sv
`timescale 1ns/1ps
module intc_edge_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] =  lvl_i[g] & ~lvl_q[g];
    assign fall_o[g] = ~lvl_i[g] &  lvl_q[g];
  end
endmodule

// File: rtl/intc_pending.sv
`timescale 1ns/1ps
module intc_pending #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic         clr_we_i,
  input  logic         load_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pend_o
);
  // One bit of next state; hardware events outrank software.
  function automatic logic next_bit(input logic cur, input logic rs, input logic fl,
                                    input logic ld, input logic cl, input logic d);
    if (rs)      return 1'b1;
    else if (fl) return 1'b0;
    else if (ld) return d;
    else if (cl) return cur & ~d;
    else         return cur;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else pend_o[g] <= next_bit(pend_o[g], rise_i[g], fall_i[g],
                                 load_we_i, clr_we_i, wdata_i[g]);
    end
  end
endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs #(
  parameter int unsigned N = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_i,
  input  intc_pkg::reg_sel_e sel_i,
  input  logic               mask_we_i,
  input  logic [N-1:0]       wdata_i,
  input  logic [N-1:0]       pend_i,
  output logic [N-1:0]       mask_o,
  output logic [N-1:0]       masked_o,
  output logic [N-1:0]       rdata_o
);
  import intc_pkg::*;

  function automatic logic [N-1:0] and_mask(input logic [N-1:0] p, input logic [N-1:0] m);
    return p & m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_o <= '0;
    else if (mask_we_i) mask_o <= wdata_i;
  end

  assign masked_o = and_mask(pend_i, mask_o);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel_i)
        SEL_PEND, SEL_LOAD: rdata_o = pend_i;
        SEL_MASK:           rdata_o = mask_o;
        SEL_MASKED:         rdata_o = masked_o;
        default:            rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_req_drv.sv
`timescale 1ns/1ps
module intc_req_drv #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] masked_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |masked_i;
  end
endmodule

// File: rtl/intc32_top.sv
`timescale 1ns/1ps
module intc32_top #(
  parameter int unsigned NSRC = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0]               src_i,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [intc_pkg::ADDR_W-1:0]   bus_addr,
  input  logic [NSRC-1:0]               bus_wdata,
  output logic [NSRC-1:0]               bus_rdata,
  output logic                          irq_o
);
  import intc_pkg::*;

  reg_sel_e        sel;
  logic            clr_we, load_we, mask_we;
  logic [NSRC-1:0] src_rise, src_fall;
  logic [NSRC-1:0] pend, mask, masked;

  assign sel     = decode_offset(bus_addr);
  assign clr_we  = bus_wr && (sel == SEL_PEND);
  assign load_we = bus_wr && (sel == SEL_LOAD);
  assign mask_we = bus_wr && (sel == SEL_MASK);

  intc_edge_det #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(src_i),
    .rise_o(src_rise), .fall_o(src_fall)
  );

  intc_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise_i(src_rise), .fall_i(src_fall),
    .clr_we_i(clr_we), .load_we_i(load_we), .wdata_i(bus_wdata),
    .pend_o(pend)
  );

  intc_regs #(.N(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd), .sel_i(sel),
    .mask_we_i(mask_we), .wdata_i(bus_wdata), .pend_i(pend),
    .mask_o(mask), .masked_o(masked), .rdata_o(bus_rdata)
  );

  intc_req_drv #(.N(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .masked_i(masked), .irq_o(irq_o)
  );
endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk #(
  parameter int unsigned N = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       rise,
  input logic [N-1:0]       fall,
  input logic [N-1:0]       pend,
  input logic [N-1:0]       mask,
  input logic               irq,
  input logic               wr,
  input logic               rd,
  input intc_pkg::reg_sel_e sel,
  input logic [N-1:0]       wdata,
  input logic [N-1:0]       rdata
);
  import intc_pkg::*;

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((pend & $past(fall)) == '0));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_PEND && rise == '0 && fall == '0)
      |=> (pend == ($past(pend) & ~$past(wdata))));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_LOAD && rise == '0 && fall == '0) |=> (pend == $past(wdata)));

  a_r6_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_MASK) |=> (mask == $past(wdata)));

  a_r7_masked_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_MASKED) |=> $stable(mask));

  a_r8_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend & mask))));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |-> (rdata == '0));

  a_r10_fall_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_LOAD && (|fall)) |=> ((pend & $past(fall)) == '0));
endmodule

bind intc32_top intc_chk #(.N(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(src_rise), .fall(src_fall),
  .pend(pend), .mask(mask), .irq(irq_o), .wr(bus_wr), .rd(bus_rd),
  .sel(sel), .wdata(bus_wdata), .rdata(bus_rdata)
);

// File: tb/sim_intc32_top.sv
`timescale 1ns/1ps
module sim_intc32_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  intc32_top #(.NSRC(32)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(8'h00, v); check("R1 pend", v, 32'h0);
    bus_read(8'h04, v); check("R1 load", v, 32'h0);
    bus_read(8'h08, v); check("R1 mask", v, 32'h0);
    bus_read(8'h0C, v); check("R1 masked", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_sources();
    logic [31:0] v;
    set_src(32'h0000_0020);
    bus_read(8'h00, v); check("R2 single rise", v, 32'h0000_0020);
    set_src(32'hA500_0023);
    bus_read(8'h00, v); check("R2 pattern rise", v, 32'hA500_0023);
    set_src(32'hA500_0003);
    bus_read(8'h00, v); check("R3 single fall", v, 32'hA500_0003);
    // line 0 stays high; clearing it must not be undone by the level
    bus_write(8'h00, 32'h0000_0001);
    @(negedge clk);
    bus_read(8'h00, v); check("R3 held high no reset", v, 32'hA500_0002);
    set_src(32'h0);
    bus_read(8'h00, v); check("R3 all fall", v, 32'h0);
  endtask

  task automatic t_software();
    logic [31:0] v;
    bus_write(8'h04, 32'hFFFF_0000);
    bus_read(8'h00, v); check("R5 load", v, 32'hFFFF_0000);
    bus_write(8'h00, 32'h0F0F_00FF);
    bus_read(8'h00, v); check("R4 w1c", v, 32'hF0F0_0000);
    bus_read(8'h04, v); check("R5 read load offset", v, 32'hF0F0_0000);
    bus_write(8'h04, 32'h0000_1234);
    bus_read(8'h00, v); check("R5 overwrite", v, 32'h0000_1234);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, v); check("R4 clear all", v, 32'h0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    bus_write(8'h08, 32'h0001_8000);
    bus_read(8'h08, v); check("R6 mask read", v, 32'h0001_8000);
    check("R8 no pending", {31'h0, irq}, 32'h0);
    bus_write(8'h04, 32'h0001_0001);  // pending updates at this edge
    check("R8 one clock lag", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R8 rises", {31'h0, irq}, 32'h1);
    bus_read(8'h0C, v); check("R7 masked read", v, 32'h0001_0000);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h08, v); check("R7 mask kept", v, 32'h0001_8000);
    bus_read(8'h00, v); check("R7 pend kept", v, 32'h0001_0001);
    bus_write(8'h08, 32'h0000_0000);
    @(negedge clk);
    check("R8 masked off", {31'h0, irq}, 32'h0);
    bus_write(8'h08, 32'h0000_0001);
    @(negedge clk);
    check("R8 low bit enables", {31'h0, irq}, 32'h1);
    bus_write(8'h00, 32'h0000_0001);
    @(negedge clk);
    check("R8 cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(8'h10, 32'hDEAD_BEEF);
    bus_write(8'h02, 32'hFFFF_FFFF);
    bus_write(8'h09, 32'hFFFF_FFFF);
    bus_read(8'h00, v); check("R9 pend untouched", v, 32'h0001_0000);
    bus_read(8'h08, v); check("R9 mask untouched", v, 32'h0000_0001);
    bus_read(8'h10, v); check("R9 read zero", v, 32'h0);
    bus_read(8'h01, v); check("R9 misaligned zero", v, 32'h0);
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    bus_write(8'h04, 32'h0);
    @(negedge clk);
    src = 32'h0000_0008; wr = 1'b1; addr = 8'h00; wdata = 32'h0000_0008;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    bus_read(8'h00, v); check("R10 rise beats clear", v, 32'h0000_0008);
    @(negedge clk);
    src = 32'h0; wr = 1'b1; addr = 8'h04; wdata = 32'h0000_0018;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    bus_read(8'h00, v); check("R10 fall beats load", v, 32'h0000_0010);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sources();
    t_software();
    t_mask_irq();
    t_unmapped();
    t_conflict();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule